// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block generates instruction fetch addresses for a small 8-bit controller whose program space is 13 bits wide. Each instruction cycle it receives one decoded action and moves the program counter to its next value. The action is one of: step, load the low byte from the ALU, jump, call, or return. The low byte of the counter is visible to software as a data register.

The upper five counter bits are never loaded from the data path directly. They come from a software-written page latch. A low-byte write takes all five latch bits. A jump or call takes only the top two latch bits and fills the eleven bits below them from the opcode immediate. Calls save the address that follows them on an eight-entry circular stack, and returns take it back.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `fetch_addr` is 0. Reset also clears the page latch, the stack pointer and every stack entry to 0.
- R2: Action code 0 (step) sets the counter to its value plus one, so 0x1FFF is followed by 0x0000. Codes 5, 6 and 7 behave exactly as step.
- R3: Action code 1 (low-byte load) sets counter bits 7:0 to `alu_res` and bits 12:8 to latch bits 4:0.
- R4: Action code 2 (jump) sets counter bits 10:0 to `imm` and bits 12:11 to latch bits 4:3.
- R5: Action code 3 (call) pushes the counter plus one (modulo 0x2000) onto the stack and loads the counter the same way as a jump.
- R6: Action code 4 (return) loads all 13 counter bits from the most recent stack entry and pops that entry.
- R7: Loads of the counter never change the page latch. The latch changes only when `latch_we` is high. A latch write takes effect for actions in the following cycle, so a load in the same cycle still uses the old latch value.
- R8: The stack is circular with eight entries. A ninth outstanding call overwrites the oldest entry. A return with no entry outstanding yields whatever the slot below the pointer holds. No flag is raised in either case.
- R9: `pcl_rd` always equals bits 7:0 of `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Decoded action: 0 step, 1 low-byte load, 2 jump, 3 call, 4 return, 5-7 step |
| imm | input | 11 | Opcode immediate target |
| alu_res | input | 8 | ALU result for the low-byte load |
| latch_we | input | 1 | Page latch write enable |
| latch_wd | input | 5 | Page latch write data |
| fetch_addr | output | 13 | Current program counter |
| pcl_rd | output | 8 | Low byte of the counter as software reads it |

## Verification
The counter, latch and stack are all single registers, so every action presented in a cycle shows up on `fetch_addr` and `pcl_rd` exactly one rising edge later. A latch write shows up only through the next load that uses it, one cycle after that. The bench drives each action at a falling edge and advances its behavioural model at the rising edge. It then compares both outputs at the next falling edge, so each comparison falls in the cycle where the result is due. Long call chains past eight levels, and returns past empty, exercise the circular stack. A random stream mixes all eight action codes with latch writes.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int ADDR_W = 13,
  parameter int LO_W   = 8,
  parameter int IMM_W  = 11,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LO_W-1:0]   alu_res,
  input  logic              latch_we,
  input  logic [ADDR_W-LO_W-1:0] latch_wd,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LO_W-1:0]   pcl_rd
);
  localparam int LAT_W = ADDR_W - LO_W;
  localparam int PG_W  = ADDR_W - IMM_W;
  localparam int SP_W  = $clog2(DEPTH);
  localparam logic [2:0] OP_LDLO = 3'd1, OP_JMP = 3'd2, OP_CALL = 3'd3, OP_RET = 3'd4;

  logic [ADDR_W-1:0] pc, pc_inc, jmp_tgt;
  logic [LAT_W-1:0]  lat;
  logic [SP_W-1:0]   sp, sp_top;
  logic [ADDR_W-1:0] stk [DEPTH];

  assign pc_inc     = pc + 1'b1;
  assign jmp_tgt    = {lat[LAT_W-1 -: PG_W], imm};
  assign sp_top     = sp - 1'b1;
  assign fetch_addr = pc;
  assign pcl_rd     = pc[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      lat <= '0;
      sp  <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      if (latch_we) lat <= latch_wd;
      case (op)
        OP_LDLO: pc <= {lat, alu_res};
        OP_JMP:  pc <= jmp_tgt;
        OP_CALL: begin
          stk[sp] <= pc_inc;
          sp      <= sp + 1'b1;
          pc      <= jmp_tgt;
        end
        OP_RET: begin
          pc <= stk[sp_top];
          sp <= sp_top;
        end
        default: pc <= pc_inc;
      endcase
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op > OP_RET) |=> pc == ADDR_W'($past(pc) + 1));

  p_ldlo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LDLO |=> pc == {$past(lat), $past(alu_res)});

  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_JMP |=> (pc[IMM_W-1:0] == $past(imm)) &&
                     (pc[ADDR_W-1:IMM_W] == $past(lat[LAT_W-1 -: PG_W])));

  p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CALL |=> sp == SP_W'($past(sp) + 1));

  p_callret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET && $past(op) == OP_CALL && $past(rst_n)) |=> pc == ADDR_W'($past(pc, 2) + 1));

  p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(lat));

  p_rdlo_r9: assert property (@(posedge clk) pcl_rd == fetch_addr[LO_W-1:0]);
endmodule

// File: tb/pc_unit_bench.sv
module pc_unit_bench;
  logic clk = 0, rst_n = 0, latch_we = 0;
  logic [2:0] op = 0;
  logic [10:0] imm = 0;
  logic [7:0] alu_res = 0;
  logic [4:0] latch_wd = 0;
  logic [12:0] fetch_addr;
  logic [7:0] pcl_rd;
  int checks = 0, fails = 0;
  int m_pc, m_lat, m_sp;
  int m_stk [8];

  pc_unit u_pc_unit (.clk, .rst_n, .op, .imm, .alu_res, .latch_we, .latch_wd, .fetch_addr, .pcl_rd);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(string req);
    checks++;
    if (fetch_addr !== 13'(m_pc) || pcl_rd !== 8'(m_pc)) begin
      fails++;
      $display("FAIL %s: actual pc=%h lo=%h expected pc=%h lo=%h", req, fetch_addr, pcl_rd, 13'(m_pc), 8'(m_pc));
    end
  endtask

  task automatic step(input int o, input int im, input int alu, input bit we, input int wd, input string req);
    int npc;
    op = 3'(o); imm = 11'(im); alu_res = 8'(alu); latch_we = we; latch_wd = 5'(wd);
    @(posedge clk);
    npc = (m_pc + 1) % 8192;
    case (o)
      1: npc = m_lat * 256 + alu;
      2: npc = (m_lat / 8) * 2048 + im;
      3: begin m_stk[m_sp] = (m_pc + 1) % 8192; m_sp = (m_sp + 1) % 8; npc = (m_lat / 8) * 2048 + im; end
      4: begin m_sp = (m_sp + 7) % 8; npc = m_stk[m_sp]; end
      default: ;
    endcase
    if (we) m_lat = wd;
    m_pc = npc;
    @(negedge clk);
    chk(req);
  endtask

  initial begin
    m_pc = 0; m_lat = 0; m_sp = 0;
    foreach (m_stk[i]) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1;
    chk("R1 after release");
    step(4, 0, 0, 0, 0, "R1 empty-stack pop of cleared entry");
    step(0, 0, 0, 0, 0, "R2 step");
    step(5, 0, 0, 0, 0, "R2 code5");
    step(6, 0, 0, 0, 0, "R2 code6");
    step(7, 0, 0, 0, 0, "R2 code7");
    step(1, 0, 8'hA5, 1, 5'h1F, "R7 same-cycle latch write unused");
    step(1, 0, 8'hFF, 0, 0, "R3 low-byte load uses latch");
    step(0, 0, 0, 0, 0, "R2 wrap to 0");
    step(2, 11'h7FF, 0, 0, 0, "R4 jump page bits");
    step(1, 0, 8'h12, 1, 5'h05, "R3 low-byte load");
    step(2, 11'h123, 0, 0, 0, "R4 jump with page 0");
    step(1, 0, 8'h34, 0, 0, "R7 latch not copied from PC");
    for (int i = 0; i < 10; i++) step(3, i * 100 + 7, 0, 1, i * 3, "R5 call chain");
    for (int i = 0; i < 10; i++) step(4, 0, 0, 0, 0, "R8 circular pops");
    step(3, 11'h400, 0, 0, 0, "R5 call");
    step(4, 0, 0, 0, 0, "R6 return");
    step(0, 0, 0, 0, 0, "R9 low byte read");
    for (int i = 0; i < 4000; i++) begin
      int o = $urandom_range(0, 7);
      step(o, $urandom_range(0, 2047), $urandom_range(0, 255), $urandom_range(0, 3) == 0,
           $urandom_range(0, 31), o == 1 ? "R3 random" : o == 2 ? "R4 random" :
           o == 3 ? "R5 random" : o == 4 ? "R6 random" : "R2 random");
    end
    rst_n = 0;
    @(posedge clk); m_pc = 0; m_lat = 0; m_sp = 0;
    foreach (m_stk[i]) m_stk[i] = 0;
    @(negedge clk);
    chk("R1 mid-run reset");
    rst_n = 1;
    step(2, 11'h055, 0, 0, 0, "R1 latch cleared");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule